// File: doc/BRIEF.md
# Bidirectional On-the-Fly AES-128 Key Scheduler

This block generates AES-128 round keys one at a time, alongside an iterative cipher round that is split into several pipeline stages. It needs no key storage. A start pulse loads a 128-bit seed into four 32-bit word registers. From then on, each scheduled step replaces the held key with its neighbour in the schedule:

- **Forward direction (encryption):** the seed is the cipher key. The schedule climbs from round 0 to round 10.
- **Reverse direction (decryption):** the seed is the final round key. The same word datapath is steered by multiplexers to recover the earlier words, so the keys come out in descending order down to the cipher key.

The scheduler does not step on every clock. It counts pulses of a round-clock enable and steps once every three of them in the forward direction and once every four in reverse. These counts match the depth of the encryption and decryption round pipelines. The divider is preloaded at start, so the first key change comes one round-clock earlier than the steady interval. This lets the key lead the first data block. The round constant is kept in its own register. It is multiplied by x after each forward step, and by the inverse of x after each reverse step. A done flag marks the end of the schedule, and the round index then holds at its final value until the next start.

Top module: `aes_ks_bidir`

## Requirements
- R1: While reset is asserted, and after its release with no start, `round_key` is all zeros, `round_idx` is 0 and `done` is 0.
- R2: In the cycle after a start pulse, `round_key` equals `seed_key` and `done` is 0. `round_idx` is 0 when `decrypt` was 0 at the start, and 10 when `decrypt` was 1.
- R3: A forward step replaces the held key with the next AES-128 round key and raises `round_idx` by one. Word 0 of the key is bits 127:96 and word 3 is bits 31:0.
- R4: A reverse step replaces the held key with the previous AES-128 round key and lowers `round_idx` by one. The seed is the round-10 key, and the final output is the cipher key.
- R5: The round constant in the top byte of the substituted word follows the sequence 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36. Forward runs use it in rising order and reverse runs use it in falling order. As a result, the standard test key 2b7e151628aed2a6abf7158809cf4f3c reaches d014f9a8c9ee2589e13f0cc8b6630ca6 at round 10.
- R6: After the first step, steps occur every 3 cycles with `adv` high in the forward direction and every 4 in reverse.
- R7: The first step after a start comes after 2 `adv` cycles in the forward direction and 3 in reverse. This is one fewer than the steady interval.
- R8: A cycle with `adv` low and no start changes none of `round_key`, `round_idx`, `done` or the divider count.
- R9: After ten steps `done` is 1. From then until the next start, `round_idx` stays at 10 (forward) or 0 (reverse), `round_key` does not change, and `adv` has no effect.
- R10: A start pulse during a run aborts it and restarts from the new seed and direction. A start pulse takes priority over `adv` in the same cycle.
- R11: Before the first start after reset, `adv` pulses leave the outputs at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the seed and direction and begin a schedule |
| decrypt | input | 1 | Direction sampled at start: 0 runs forward, 1 runs in reverse |
| adv | input | 1 | Round-clock enable counted by the divider |
| seed_key | input | 128 | Cipher key (forward) or round-10 key (reverse) |
| round_key | output | 128 | Currently held round key |
| round_idx | output | 4 | Round number of `round_key` |
| done | output | 1 | Schedule finished; outputs frozen until next start |

## Verification
The bench builds the block with its default parameters:
- ten rounds;
- divider counts 3 and 4;
- a lead of one;
- the table-based S-box variant.

Because the two divider counts are unequal, a wrong divider limit for either direction shows up as a first-step or interval count that differs from the expected 2/3 or 3/4. Ten rounds let the forward and reverse end points be compared against the published test-key values. They also let a mid-run restart that switches direction check that the round constant is reloaded rather than carried over.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

   typedef enum logic {
      KS_FWD = 1'b0,
      KS_REV = 1'b1
   } ks_dir_e;

   // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   // multiply by x^-1 (exact inverse of gf_xtime)
   function automatic logic [7:0] gf_xtime_inv(input logic [7:0] b);
      return b[0] ? (((b ^ 8'h1b) >> 1) | 8'h80) : (b >> 1);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_xtime(sh);
      end
      return acc;
   endfunction

   // a^254 by square-and-multiply; maps 0 to 0
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] sq;
      logic [7:0] r;
      sq = a;
      r  = 8'h01;
      for (int k = 1; k < 8; k++) begin
         sq = gf_mul(sq, sq);
         r  = gf_mul(r, sq);
      end
      return r;
   endfunction

   function automatic logic [7:0] sbox_calc(input logic [7:0] a);
      logic [7:0] v;
      v = gf_inv(a);
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

   // round constant used to produce round n (n >= 1)
   function automatic logic [7:0] rcon_at(input int n);
      logic [7:0] r;
      r = 8'h01;
      for (int k = 1; k < n; k++) r = gf_xtime(r);
      return r;
   endfunction

   function automatic logic [31:0] rot_word(input logic [31:0] w);
      return {w[23:0], w[31:24]};
   endfunction

endpackage

// File: rtl/ks_sbox_word.sv
module ks_sbox_word
   import aes_ks_pkg::*;
#(
   parameter int SBOX_IMPL = 1,
   parameter int WORD_W    = 32
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NBYTES = WORD_W / 8;

   if (SBOX_IMPL != 0 && SBOX_IMPL != 1) begin : g_bad_impl
      $error("ks_sbox_word: SBOX_IMPL must be 0 or 1");
   end
   if (WORD_W % 8 != 0) begin : g_bad_width
      $error("ks_sbox_word: WORD_W must be a whole number of bytes");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic [7:0] x;
      assign x = din[8*b +: 8];
      if (SBOX_IMPL == 1) begin : g_lut
         // table filled with constants computed at elaboration
         logic [7:0] lut [256];
         for (genvar v = 0; v < 256; v++) begin : g_ent
            localparam logic [7:0] ENT = sbox_calc(8'(v));
            assign lut[v] = ENT;
         end
         assign dout[8*b +: 8] = lut[x];
      end else begin : g_calc
         // field inversion plus affine map in logic
         assign dout[8*b +: 8] = sbox_calc(x);
      end
   end

endmodule

// File: rtl/ks_rcon_gen.sv
module ks_rcon_gen
   import aes_ks_pkg::*;
#(
   parameter int NUM_ROUNDS = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  ks_dir_e    dir,
   input  logic       step,
   output logic [7:0] rcon
);
   localparam logic [7:0] RC_FIRST = rcon_at(1);
   localparam logic [7:0] RC_LAST  = rcon_at(NUM_ROUNDS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcon <= RC_FIRST;
      end else if (load) begin
         rcon <= (dir == KS_REV) ? RC_LAST : RC_FIRST;
      end else if (step) begin
         rcon <= (dir == KS_REV) ? gf_xtime_inv(rcon) : gf_xtime(rcon);
      end
   end

endmodule

// File: rtl/ks_pace.sv
module ks_pace
   import aes_ks_pkg::*;
#(
   parameter int ENC_DIV = 3,
   parameter int DEC_DIV = 4,
   parameter int LEAD    = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  ks_dir_e dir,
   input  logic    run,
   input  logic    adv,
   output logic    step
);
   localparam int MAXDIV = (ENC_DIV > DEC_DIV) ? ENC_DIV : DEC_DIV;
   localparam int CW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

   if (ENC_DIV < 1 || DEC_DIV < 1) begin : g_bad_div
      $error("ks_pace: divider counts must be at least 1");
   end
   if (LEAD < 0 || LEAD >= ENC_DIV || LEAD >= DEC_DIV) begin : g_bad_lead
      $error("ks_pace: LEAD must be below both divider counts");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   if (ENC_DIV == DEC_DIV) begin : g_one_lim
      assign lim = CW'(ENC_DIV - 1);
   end else begin : g_two_lim
      assign lim = (dir == KS_REV) ? CW'(DEC_DIV - 1) : CW'(ENC_DIV - 1);
   end

   assign step = run && adv && !start && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(LEAD);
      end else if (run && adv) begin
         cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ks_word_path.sv
module ks_word_path
   import aes_ks_pkg::*;
#(
   parameter int SBOX_IMPL = 1,
   parameter int NK        = 4
) (
   input  logic [32*NK-1:0] cur,
   input  ks_dir_e          dir,
   input  logic [7:0]       rcon,
   output logic [32*NK-1:0] nxt
);
   logic [31:0] w [NK];
   logic [31:0] y [NK];
   logic [31:0] g_in;
   logic [31:0] g_rot;
   logic [31:0] g_sub;
   logic [31:0] g_out;

   for (genvar k = 0; k < NK; k++) begin : g_split
      assign w[k] = cur[32*(NK-1-k) +: 32];
      assign nxt[32*(NK-1-k) +: 32] = y[k];
   end

   // reverse: g acts on the recovered last word, i.e. w3 ^ w2
   assign g_in  = (dir == KS_REV) ? (w[NK-1] ^ w[NK-2]) : w[NK-1];
   assign g_rot = rot_word(g_in);

   ks_sbox_word #(.SBOX_IMPL(SBOX_IMPL), .WORD_W(32)) u_sub (
      .din  (g_rot),
      .dout (g_sub)
   );

   assign g_out = g_sub ^ {rcon, 24'h000000};
   assign y[0]  = w[0] ^ g_out;

   // XOR chain with a multiplexer between stages:
   // forward feeds the freshly computed word, reverse the old neighbour
   for (genvar k = 1; k < NK; k++) begin : g_chain
      assign y[k] = w[k] ^ ((dir == KS_REV) ? w[k-1] : y[k-1]);
   end

endmodule

// File: rtl/aes_ks_bidir.sv
module aes_ks_bidir
   import aes_ks_pkg::*;
#(
   parameter int NUM_ROUNDS = 10,
   parameter int ENC_DIV    = 3,
   parameter int DEC_DIV    = 4,
   parameter int LEAD       = 1,
   parameter int SBOX_IMPL  = 1,
   localparam int NK        = 4,
   localparam int KEY_W     = 32 * NK,
   localparam int IDX_W     = $clog2(NUM_ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             decrypt,
   input  logic             adv,
   input  logic [KEY_W-1:0] seed_key,
   output logic [KEY_W-1:0] round_key,
   output logic [IDX_W-1:0] round_idx,
   output logic             done
);
   if (NUM_ROUNDS < 1 || NUM_ROUNDS > 14) begin : g_bad_rounds
      $error("aes_ks_bidir: NUM_ROUNDS out of range");
   end

   ks_dir_e          dir_q;
   ks_dir_e          dir_sel;
   logic             busy_q;
   logic             done_q;
   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] key_nxt;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       rcon;
   logic             step;
   logic             last_step;

   assign dir_sel = start ? ks_dir_e'(decrypt) : dir_q;

   ks_pace #(.ENC_DIV(ENC_DIV), .DEC_DIV(DEC_DIV), .LEAD(LEAD)) u_pace (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .dir   (dir_q),
      .run   (busy_q),
      .adv   (adv),
      .step  (step)
   );

   ks_rcon_gen #(.NUM_ROUNDS(NUM_ROUNDS)) u_rcon (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .dir   (dir_sel),
      .step  (step),
      .rcon  (rcon)
   );

   ks_word_path #(.SBOX_IMPL(SBOX_IMPL), .NK(NK)) u_path (
      .cur  (key_q),
      .dir  (dir_q),
      .rcon (rcon),
      .nxt  (key_nxt)
   );

   assign last_step = (dir_q == KS_REV) ? (idx_q == IDX_W'(1))
                                        : (idx_q == IDX_W'(NUM_ROUNDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         idx_q  <= '0;
         dir_q  <= KS_FWD;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start) begin
         key_q  <= seed_key;
         idx_q  <= decrypt ? IDX_W'(NUM_ROUNDS) : '0;
         dir_q  <= ks_dir_e'(decrypt);
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (step) begin
         key_q <= key_nxt;
         idx_q <= (dir_q == KS_REV) ? idx_q - 1'b1 : idx_q + 1'b1;
         if (last_step) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign round_key = key_q;
   assign round_idx = idx_q;
   assign done      = done_q;

endmodule

// File: rtl/aes_ks_bidir_chk.sv
module aes_ks_bidir_chk #(
   parameter int NUM_ROUNDS = 10,
   parameter int IDX_W      = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             adv,
   input logic [127:0]     round_key,
   input logic [IDX_W-1:0] round_idx,
   input logic             done
);

   // R8
   adv_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !adv) |=> ($stable(round_key) && $stable(round_idx) && $stable(done)));

   // R9
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(round_key) && $stable(round_idx)));

   // R9
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      round_idx <= IDX_W'(NUM_ROUNDS));

   // R9
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (round_idx == '0 || round_idx == IDX_W'(NUM_ROUNDS)));

   // R3 R4
   idx_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((round_idx == $past(round_idx))
                  || (round_idx == IDX_W'($past(round_idx) + 1'b1))
                  || (round_idx == IDX_W'($past(round_idx) - 1'b1))));

   // R2 R10
   start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);

endmodule

bind aes_ks_bidir aes_ks_bidir_chk #(.NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .adv       (adv),
   .round_key (round_key),
   .round_idx (round_idx),
   .done      (done)
);

// File: tb/tb_aes_ks_bidir.sv
module tb_aes_ks_bidir;
   localparam int CLK_PERIOD = 10;
   localparam int NR         = 10;
   localparam int ENC_DIV    = 3;
   localparam int DEC_DIV    = 4;
   localparam int LEAD       = 1;
   localparam logic [127:0] KEY_A      = 128'h2b7e151628aed2a6abf7158809cf4f3c;
   localparam logic [127:0] KEY_A_LAST = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
   localparam logic [127:0] KEY_B      = 128'h000102030405060708090a0b0c0d0e0f;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         decrypt = 1'b0;
   logic         adv = 1'b0;
   logic [127:0] seed_key = '0;
   logic [127:0] round_key;
   logic [3:0]   round_idx;
   logic         done;

   always #(CLK_PERIOD/2) clk = ~clk;

   aes_ks_bidir #(.NUM_ROUNDS(NR), .ENC_DIV(ENC_DIV), .DEC_DIV(DEC_DIV),
                  .LEAD(LEAD), .SBOX_IMPL(1)) dut (
      .clk (clk), .rst_n (rst_n), .start (start), .decrypt (decrypt),
      .adv (adv), .seed_key (seed_key), .round_key (round_key),
      .round_idx (round_idx), .done (done)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int sb [256];
   logic [127:0] sched [11];

   task automatic chk128(string tag, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic chk_int(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   function automatic int bmul(int a, int b);
      int p = 0;
      int x = a;
      for (int i = 0; i < 8; i++) begin
         if (((b >> i) & 1) == 1) p = p ^ x;
         x = x << 1;
         if ((x & 'h100) != 0) x = x ^ 'h11b;
      end
      return p;
   endfunction

   task automatic build_sbox();
      for (int x = 0; x < 256; x++) begin
         int inv = 0;
         int s = 0;
         if (x != 0)
            for (int y = 1; y < 256; y++) if (bmul(x, y) == 1) inv = y;
         for (int i = 0; i < 8; i++) begin
            int bit_v;
            bit_v = ((inv >> i) ^ (inv >> ((i + 4) % 8)) ^ (inv >> ((i + 5) % 8))
                    ^ (inv >> ((i + 6) % 8)) ^ (inv >> ((i + 7) % 8)) ^ ('h63 >> i)) & 1;
            s = s | (bit_v << i);
         end
         sb[x] = s;
      end
   endtask

   task automatic build_sched(logic [127:0] k);
      logic [31:0] w [44];
      logic [31:0] t;
      int rc = 1;
      for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         t = w[i-1];
         if (i % 4 == 0) begin
            t = {8'(sb[t[23:16]]), 8'(sb[t[15:8]]), 8'(sb[t[7:0]]), 8'(sb[t[31:24]])}
                ^ {8'(rc), 24'h0};
            rc = bmul(rc, 2);
         end
         w[i] = w[i-4] ^ t;
      end
      for (int r = 0; r <= NR; r++) sched[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
   endtask

   // behavioural reference model
   bit m_loaded = 0;
   bit m_dec = 0;
   bit m_busy = 0;
   bit m_done = 0;
   int m_idx = 0;
   int m_cnt = 0;
   logic [127:0] m_sched [11];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_loaded = 0; m_dec = 0; m_busy = 0; m_done = 0; m_idx = 0; m_cnt = 0;
      end else if (start) begin
         m_loaded = 1; m_dec = decrypt; m_busy = 1; m_done = 0;
         m_idx = decrypt ? NR : 0; m_cnt = LEAD; m_sched = sched;
      end else if (m_busy && adv) begin
         if (m_cnt == (m_dec ? DEC_DIV : ENC_DIV) - 1) begin
            m_cnt = 0;
            m_idx = m_dec ? m_idx - 1 : m_idx + 1;
            if ((m_dec && m_idx == 0) || (!m_dec && m_idx == NR)) begin
               m_busy = 0; m_done = 1;
            end
         end else begin
            m_cnt++;
         end
      end
   end

   always @(negedge clk) begin
      logic [127:0] exp_key;
      exp_key = m_loaded ? m_sched[m_idx] : '0;
      chk128("R3 R4 R8 per-cycle key", round_key, exp_key);
      chk_int("R6 R7 R11 per-cycle idx", int'(round_idx), m_idx);
      chk_int("R9 R10 per-cycle done", int'(done), int'(m_done));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         failures++;
         $display("FAIL watchdog (all requirements) got=timeout exp=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic count_to_change(output int n);
      logic [3:0] base;
      base = round_idx;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (round_idx == base && n < 40);
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int n;
      logic [127:0] hold;
      build_sbox();
      build_sched(KEY_A);
      repeat (3) @(negedge clk);
      chk128("R1 reset key", round_key, '0);
      chk_int("R1 reset idx", int'(round_idx), 0);
      chk_int("R1 reset done", int'(done), 0);
      rst_n = 1'b1;

      // R11: adv before any start
      adv = 1'b1;
      repeat (5) @(negedge clk);
      chk128("R11 adv before start key", round_key, '0);
      chk_int("R11 adv before start idx", int'(round_idx), 0);
      adv = 1'b0;

      // forward run
      seed_key = sched[0]; decrypt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk128("R2 forward load key", round_key, KEY_A);
      chk_int("R2 forward load idx", int'(round_idx), 0);
      adv = 1'b1;
      count_to_change(n);
      chk_int("R7 forward first step spacing", n, ENC_DIV - LEAD);
      chk128("R3 round 1 key", round_key, sched[1]);
      count_to_change(n);
      chk_int("R6 forward step interval", n, ENC_DIV);
      adv = 1'b0;
      hold = round_key;
      repeat (6) @(negedge clk);
      chk128("R8 adv low holds key", round_key, hold);
      chk_int("R8 adv low holds idx", int'(round_idx), 2);
      adv = 1'b1;
      count_to_change(n);
      chk_int("R8 divider count kept across idle", n, ENC_DIV);
      wait_done();
      chk128("R5 forward final key", round_key, KEY_A_LAST);
      chk_int("R9 forward done idx", int'(round_idx), NR);
      repeat (8) @(negedge clk);
      chk128("R9 saturated key", round_key, KEY_A_LAST);
      chk_int("R9 saturated idx", int'(round_idx), NR);
      chk_int("R9 done held", int'(done), 1);

      // reverse run
      adv = 1'b0;
      seed_key = sched[NR]; decrypt = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk128("R2 reverse load key", round_key, KEY_A_LAST);
      chk_int("R2 reverse load idx", int'(round_idx), NR);
      chk_int("R2 reverse done cleared", int'(done), 0);
      adv = 1'b1;
      count_to_change(n);
      chk_int("R7 reverse first step spacing", n, DEC_DIV - LEAD);
      chk128("R4 round 9 key", round_key, sched[NR-1]);
      count_to_change(n);
      chk_int("R6 reverse step interval", n, DEC_DIV);
      wait_done();
      chk128("R4 R5 reverse final key", round_key, KEY_A);
      chk_int("R4 reverse final idx", int'(round_idx), 0);

      // restart mid-run with direction change, adv kept high
      build_sched(KEY_B);
      seed_key = KEY_B; decrypt = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      chk_int("R10 mid run idx", int'(round_idx), 3);
      seed_key = sched[NR]; decrypt = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk128("R10 restart key", round_key, sched[NR]);
      chk_int("R10 restart idx", int'(round_idx), NR);
      chk_int("R10 restart done", int'(done), 0);
      wait_done();
      chk128("R10 R4 reverse after restart", round_key, KEY_B);
      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule